// File: doc/BRIEF.md
# Video Input Qualify and Decimate

This block sits at the raw-video entry of a compression pipeline. On every pixel clock it decides whether the edge carries a usable pixel, and forwards that pixel with a valid flag and its horizontal and vertical position within the current field. Whether the per-cycle qualifier input is honoured depends on the selected video mode. In the two half-rate modes, separate-component and grayscale, the qualifier marks the cycles that carry a pixel. In the two multiplexed modes, multiplexed-component and embedded-sync, the qualifier is ignored unless stalling is enabled. With stalling enabled, a low qualifier pauses the interface.

At every accepted field boundary the block decides whether the new field goes to the compressor. Given a discard count N, it keeps one field and then drops the next N, which lowers the field rate for low-bitrate links. It also presents a field signal whose polarity can be inverted, for neighbours that expect the opposite sense.

All configuration arrives on plain input ports and is read every cycle.

Top module: `vid_qual_decim`

## Requirements
- R1: In modes 0 (separate-component) and 1 (grayscale), a cycle is accepted exactly when `qual_i` is high. One cycle later `pix_valid_o` equals that `qual_i` value, and `pix_o` carries the `pix_i` sampled on that accepted cycle.
- R2: In modes 2 (multiplexed) and 3 (embedded-sync) with `stall_en_i` low, every cycle is accepted whatever `qual_i` is, and `pix_valid_o` is high one cycle later.
- R3: In modes 2 and 3 with `stall_en_i` high, a cycle with `qual_i` low is not accepted. After it `pix_valid_o` is low and `pix_o`, `pix_x_o` and `line_y_o` keep their previous values.
- R4: Position follows accepted cycles only:
  - an accepted `field_start_i` sets `pix_x_o` and `line_y_o` to 0;
  - otherwise an accepted `line_start_i` sets `pix_x_o` to 0 and adds 1 to `line_y_o`;
  - any other accepted cycle adds 1 to `pix_x_o`, wrapping modulo 2^X_W;
  - strobes on cycles that are not accepted have no effect.
- R5: At each accepted field start, a down-counter is examined:
  - if it is zero, the field is kept (`field_keep_o` = 1) and the counter reloads from `drop_cnt_i`;
  - otherwise the field is dropped (`field_keep_o` = 0) and the counter decrements.

  The counter is zero after reset, so the first field is kept. A count of N keeps one field in every N+1, and a count of 0 keeps all fields. `field_keep_o` changes only at accepted field starts.
- R6: A new `drop_cnt_i` value takes effect only when the counter next reloads, so a drop run already under way is finished with the old count.
- R7: An accepted field start latches `field_id_i` (0 = field 1, 1 = field 2). `field_o` equals the latched value XOR `fld_inv_i`, and a change of `fld_inv_i` shows on `field_o` in the same cycle.
- R8: After reset, `pix_valid_o`, `pix_o`, `pix_x_o`, `line_y_o` and `field_keep_o` are 0. The latched field id is 0, so `field_o` equals `fld_inv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 2 | Video mode: 0 separate, 1 grayscale, 2 multiplexed, 3 embedded-sync |
| stall_en_i | input | 1 | Lets the qualifier pause the multiplexed modes |
| qual_i | input | 1 | Per-cycle pixel qualifier |
| pix_i | input | PIX_W | Pixel data |
| line_start_i | input | 1 | Marks the first pixel of a line |
| field_start_i | input | 1 | Marks the first pixel of a field |
| field_id_i | input | 1 | Field identity at field start (0 = field 1) |
| drop_cnt_i | input | DROP_W | Number of fields discarded after each kept field |
| fld_inv_i | input | 1 | Inverts the field output |
| pix_valid_o | output | 1 | Pixel on pix_o is valid |
| pix_o | output | PIX_W | Qualified pixel data |
| pix_x_o | output | X_W | Pixel index within the line |
| line_y_o | output | Y_W | Line index within the field |
| field_keep_o | output | 1 | Current field goes to the compressor |
| field_o | output | 1 | Field signal with selected polarity |

## Verification
The bench concentrates on a few corner cases.

- Strobes that land on stalled or unqualified cycles must be ignored. A design that honoured them would zero or step the position counters early.
- A low qualifier must not be honoured in a multiplexed mode without stall enable. A design that got this wrong would drop pixels that should flow.
- The discard count changes in the middle of a drop run. A design that reloaded at once would shorten or stretch that run, and one that never reloaded would keep the old rate.
- Polarity is flipped between field starts. A design that latched the inversion at the boundary would show the change a field late.

// File: rtl/vqd_pkg.sv
package vqd_pkg;

   typedef enum logic [1:0] {
      VM_SEPARATE = 2'd0,
      VM_GRAY     = 2'd1,
      VM_MUXED    = 2'd2,
      VM_EMBEDDED = 2'd3
   } vid_mode_e;

   // Multiplexed modes deliver a pixel every clock; the others deliver one
   // every other clock and rely on the qualifier.
   function automatic logic mode_is_muxed(input logic [1:0] mode);
      return (mode == VM_MUXED) || (mode == VM_EMBEDDED);
   endfunction

   function automatic logic cycle_accepted(input logic [1:0] mode,
                                           input logic       stall_en,
                                           input logic       qual);
      if (mode_is_muxed(mode)) return stall_en ? qual : 1'b1;
      return qual;
   endfunction

endpackage

// File: rtl/vqd_qualify.sv
module vqd_qualify #(
   parameter int unsigned PIX_W     = 20,
   parameter bit          HOLD_DATA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel_i,
   input  logic             stall_en_i,
   input  logic             qual_i,
   input  logic [PIX_W-1:0] pix_i,
   output logic             accept_o,
   output logic             pix_valid_o,
   output logic [PIX_W-1:0] pix_o
);
   import vqd_pkg::*;

   assign accept_o = cycle_accepted(mode_sel_i, stall_en_i, qual_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_valid_o <= 1'b0;
      else        pix_valid_o <= accept_o;
   end

   generate
      if (HOLD_DATA) begin : g_hold
         // Data register keeps its last pixel across stalled cycles.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pix_o <= '0;
            else if (accept_o) pix_o <= pix_i;
         end
      end else begin : g_zero
         // Data register blanks to zero when no pixel is accepted.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pix_o <= '0;
            else        pix_o <= accept_o ? pix_i : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/vqd_position.sv
module vqd_position #(
   parameter int unsigned X_W = 12,
   parameter int unsigned Y_W = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           accept_i,
   input  logic           line_start_i,
   input  logic           field_start_i,
   output logic [X_W-1:0] pix_x_o,
   output logic [Y_W-1:0] line_y_o
);
   localparam logic [X_W-1:0] X_ONE = X_W'(1);
   localparam logic [Y_W-1:0] Y_ONE = Y_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_x_o  <= '0;
         line_y_o <= '0;
      end else if (accept_i) begin
         if (field_start_i) begin
            pix_x_o  <= '0;
            line_y_o <= '0;
         end else if (line_start_i) begin
            pix_x_o  <= '0;
            line_y_o <= line_y_o + Y_ONE;
         end else begin
            pix_x_o  <= pix_x_o + X_ONE;
         end
      end
   end

endmodule

// File: rtl/vqd_field_decim.sv
module vqd_field_decim #(
   parameter int unsigned DROP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fstart_i,
   input  logic              field_id_i,
   input  logic [DROP_W-1:0] drop_cnt_i,
   input  logic              fld_inv_i,
   output logic              field_keep_o,
   output logic              field_o
);
   localparam logic [DROP_W-1:0] CNT_ONE = DROP_W'(1);

   logic [DROP_W-1:0] skip_q;
   logic              fid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_q       <= '0;
         field_keep_o <= 1'b0;
         fid_q        <= 1'b0;
      end else if (fstart_i) begin
         fid_q <= field_id_i;
         if (skip_q == '0) begin
            field_keep_o <= 1'b1;
            skip_q       <= drop_cnt_i;
         end else begin
            field_keep_o <= 1'b0;
            skip_q       <= skip_q - CNT_ONE;
         end
      end
   end

   assign field_o = fid_q ^ fld_inv_i;

endmodule

// File: rtl/vid_qual_decim.sv
module vid_qual_decim #(
   parameter int unsigned PIX_W     = 20,
   parameter int unsigned X_W       = 12,
   parameter int unsigned Y_W       = 11,
   parameter int unsigned DROP_W    = 4,
   parameter bit          HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel_i,
   input  logic              stall_en_i,
   input  logic              qual_i,
   input  logic [PIX_W-1:0]  pix_i,
   input  logic              line_start_i,
   input  logic              field_start_i,
   input  logic              field_id_i,
   input  logic [DROP_W-1:0] drop_cnt_i,
   input  logic              fld_inv_i,
   output logic              pix_valid_o,
   output logic [PIX_W-1:0]  pix_o,
   output logic [X_W-1:0]    pix_x_o,
   output logic [Y_W-1:0]    line_y_o,
   output logic              field_keep_o,
   output logic              field_o
);
   generate
      if (PIX_W < 1 || PIX_W > 64) begin : g_bad_pix
         $error("vid_qual_decim: PIX_W out of range");
      end
      if (X_W < 2 || X_W > 16) begin : g_bad_x
         $error("vid_qual_decim: X_W out of range");
      end
      if (Y_W < 2 || Y_W > 16) begin : g_bad_y
         $error("vid_qual_decim: Y_W out of range");
      end
      if (DROP_W < 1 || DROP_W > 8) begin : g_bad_drop
         $error("vid_qual_decim: DROP_W out of range");
      end
   endgenerate

   logic accept;
   logic fstart_acc;

   vqd_qualify #(.PIX_W(PIX_W), .HOLD_DATA(HOLD_DATA)) u_qual (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_sel_i  (mode_sel_i),
      .stall_en_i  (stall_en_i),
      .qual_i      (qual_i),
      .pix_i       (pix_i),
      .accept_o    (accept),
      .pix_valid_o (pix_valid_o),
      .pix_o       (pix_o)
   );

   vqd_position #(.X_W(X_W), .Y_W(Y_W)) u_pos (
      .clk           (clk),
      .rst_n         (rst_n),
      .accept_i      (accept),
      .line_start_i  (line_start_i),
      .field_start_i (field_start_i),
      .pix_x_o       (pix_x_o),
      .line_y_o      (line_y_o)
   );

   assign fstart_acc = accept & field_start_i;

   vqd_field_decim #(.DROP_W(DROP_W)) u_fld (
      .clk          (clk),
      .rst_n        (rst_n),
      .fstart_i     (fstart_acc),
      .field_id_i   (field_id_i),
      .drop_cnt_i   (drop_cnt_i),
      .fld_inv_i    (fld_inv_i),
      .field_keep_o (field_keep_o),
      .field_o      (field_o)
   );

endmodule

// File: rtl/vqd_checker.sv
module vqd_checker #(
   parameter int unsigned X_W = 12,
   parameter int unsigned Y_W = 11
) (
   input logic           clk,
   input logic           rst_n,
   input logic [1:0]     mode_sel_i,
   input logic           stall_en_i,
   input logic           qual_i,
   input logic           line_start_i,
   input logic           field_start_i,
   input logic           pix_valid_o,
   input logic [X_W-1:0] pix_x_o,
   input logic [Y_W-1:0] line_y_o,
   input logic           field_keep_o
);
   logic muxed;
   logic acc;
   assign muxed = mode_sel_i[1];
   assign acc   = muxed ? (stall_en_i ? qual_i : 1'b1) : qual_i;

   assert_half_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !muxed |=> pix_valid_o == $past(qual_i));

   assert_free_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (muxed && !stall_en_i) |=> pix_valid_o);

   assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (muxed && stall_en_i && !qual_i) |=>
         (!pix_valid_o && $stable(pix_x_o) && $stable(line_y_o)));

   assert_field_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && field_start_i) |=> (pix_x_o == '0 && line_y_o == '0));

   assert_pixel_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !field_start_i && !line_start_i) |=>
         pix_x_o == X_W'($past(pix_x_o) + 1'b1));

   assert_keep_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && field_start_i) |=> $stable(field_keep_o));

endmodule

bind vid_qual_decim vqd_checker #(.X_W(X_W), .Y_W(Y_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_sel_i    (mode_sel_i),
   .stall_en_i    (stall_en_i),
   .qual_i        (qual_i),
   .line_start_i  (line_start_i),
   .field_start_i (field_start_i),
   .pix_valid_o   (pix_valid_o),
   .pix_x_o       (pix_x_o),
   .line_y_o      (line_y_o),
   .field_keep_o  (field_keep_o)
);

// File: tb/vid_qual_decim_tb.sv
module vid_qual_decim_tb;
   localparam int PIX_W = 20;
   localparam int X_W = 12;
   localparam int Y_W = 11;
   localparam int DROP_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode_sel_i = 2'd0;
   logic stall_en_i = 1'b0;
   logic qual_i = 1'b0;
   logic [PIX_W-1:0] pix_i = '0;
   logic line_start_i = 1'b0;
   logic field_start_i = 1'b0;
   logic field_id_i = 1'b0;
   logic [DROP_W-1:0] drop_cnt_i = '0;
   logic fld_inv_i = 1'b0;
   logic pix_valid_o;
   logic [PIX_W-1:0] pix_o;
   logic [X_W-1:0] pix_x_o;
   logic [Y_W-1:0] line_y_o;
   logic field_keep_o;
   logic field_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // expected-state model built from the requirements
   logic e_valid;
   logic [PIX_W-1:0] e_pix;
   logic [X_W-1:0] e_x;
   logic [Y_W-1:0] e_y;
   logic e_keep;
   logic e_fid;
   logic [DROP_W-1:0] e_skip;

   always #5 clk = ~clk;

   vid_qual_decim #(.PIX_W(PIX_W), .X_W(X_W), .Y_W(Y_W), .DROP_W(DROP_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel_i), .stall_en_i(stall_en_i),
      .qual_i(qual_i), .pix_i(pix_i), .line_start_i(line_start_i),
      .field_start_i(field_start_i), .field_id_i(field_id_i),
      .drop_cnt_i(drop_cnt_i), .fld_inv_i(fld_inv_i),
      .pix_valid_o(pix_valid_o), .pix_o(pix_o), .pix_x_o(pix_x_o),
      .line_y_o(line_y_o), .field_keep_o(field_keep_o), .field_o(field_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_accept(input logic [1:0] m, input logic s, input logic q);
      // R1: modes 0/1 follow the qualifier; R2/R3: modes 2/3 only when stall enabled
      if (m >= 2'd2) return s ? q : 1'b1;
      return q;
   endfunction

   task automatic model_reset();
      e_valid = 0; e_pix = '0; e_x = '0; e_y = '0;
      e_keep = 0; e_fid = 0; e_skip = '0;
   endtask

   task automatic model_step();
      logic a;
      a = exp_accept(mode_sel_i, stall_en_i, qual_i);
      e_valid = a;
      if (a) begin
         e_pix = pix_i;
         if (field_start_i) begin
            e_x = '0; e_y = '0;
            e_fid = field_id_i;
            if (e_skip == '0) begin e_keep = 1'b1; e_skip = drop_cnt_i; end
            else begin e_keep = 1'b0; e_skip = e_skip - 1'b1; end
         end else if (line_start_i) begin
            e_x = '0; e_y = e_y + 1'b1;
         end else begin
            e_x = e_x + 1'b1;
         end
      end
   endtask

   task automatic compare_all(input string tag);
      check({tag, " R1/R2 valid"}, 32'(pix_valid_o), 32'(e_valid));
      check({tag, " R1 pix"}, 32'(pix_o), 32'(e_pix));
      check({tag, " R4 x"}, 32'(pix_x_o), 32'(e_x));
      check({tag, " R4 y"}, 32'(line_y_o), 32'(e_y));
      check({tag, " R5 keep"}, 32'(field_keep_o), 32'(e_keep));
      check({tag, " R7 field"}, 32'(field_o), 32'(e_fid ^ fld_inv_i));
   endtask

   // one clock: inputs already driven at negedge, apply edge, compare after it
   task automatic cycle(input string tag);
      model_step();
      @(posedge clk);
      #1;
      compare_all(tag);
      @(negedge clk);
      line_start_i = 0;
      field_start_i = 0;
   endtask

   task automatic field_begin(input logic fid, input string tag);
      qual_i = 1; field_start_i = 1; field_id_i = fid;
      cycle(tag);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 valid", 32'(pix_valid_o), 0);
      check("R8 pix", 32'(pix_o), 0);
      check("R8 x", 32'(pix_x_o), 0);
      check("R8 y", 32'(line_y_o), 0);
      check("R8 keep", 32'(field_keep_o), 0);
      fld_inv_i = 1; #1;
      check("R8 field follows inversion", 32'(field_o), 1);
      fld_inv_i = 0; #1;
      check("R8 field", 32'(field_o), 0);
      rst_n = 1;
      @(negedge clk);

      // R1: half-rate mode alternating qualifier
      mode_sel_i = 2'd0;
      for (int i = 0; i < 8; i++) begin
         qual_i = i[0]; pix_i = PIX_W'(i * 7 + 3);
         cycle("R1 half-rate");
      end
      // R2: multiplexed, stall disabled, qualifier low still accepted
      mode_sel_i = 2'd2; stall_en_i = 0;
      for (int i = 0; i < 4; i++) begin
         qual_i = 0; pix_i = PIX_W'(100 + i);
         cycle("R2 free-run");
      end
      check("R2 valid with qual low", 32'(pix_valid_o), 1);
      // R3/R4: stall with strobes on stalled cycles
      stall_en_i = 1; mode_sel_i = 2'd3;
      qual_i = 0; field_start_i = 1; line_start_i = 1; pix_i = 'h55;
      cycle("R3 stalled strobes");
      check("R3 x held", 32'(pix_x_o), 32'(e_x));
      check("R3 valid low", 32'(pix_valid_o), 0);
      qual_i = 1; line_start_i = 1;
      cycle("R4 line start");
      check("R4 y stepped", 32'(line_y_o), 1);

      // R5: discard count 3 keeps one field in four
      drop_cnt_i = 4'd3; fld_inv_i = 0;
      for (int f = 0; f < 8; f++) begin
         field_begin(f[0], "R5 decimate");
         check("R5 pattern", 32'(field_keep_o), 32'((f % 4) == 0));
         qual_i = 1; cycle("R5 body");
      end
      // R6: change count mid-run; run finishes with old count
      field_begin(0, "R6 kept");
      check("R6 kept", 32'(field_keep_o), 1);
      drop_cnt_i = 4'd1;
      field_begin(1, "R6 old run 1");
      check("R6 still dropping", 32'(field_keep_o), 0);
      field_begin(0, "R6 old run 2");
      field_begin(1, "R6 old run 3");
      check("R6 old run complete", 32'(field_keep_o), 0);
      field_begin(0, "R6 reload");
      check("R6 kept after run", 32'(field_keep_o), 1);
      field_begin(1, "R6 new rate drop");
      check("R6 new rate drop", 32'(field_keep_o), 0);
      field_begin(0, "R6 new rate keep");
      check("R6 new rate keep", 32'(field_keep_o), 1);
      // R7: polarity flips immediately
      field_begin(1, "R7 field2");
      fld_inv_i = 1; #1;
      check("R7 inverted now", 32'(field_o), 0);
      fld_inv_i = 0; #1;
      check("R7 normal", 32'(field_o), 1);

      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         if (i % 50 == 0) begin
            mode_sel_i = 2'($urandom_range(0, 3));
            stall_en_i = 1'($urandom_range(0, 1));
            drop_cnt_i = DROP_W'($urandom_range(0, 3));
         end
         if (i % 37 == 0) fld_inv_i = 1'($urandom_range(0, 1));
         qual_i = 1'($urandom_range(0, 2) != 0);
         pix_i = PIX_W'($urandom);
         line_start_i = ($urandom_range(0, 15) == 0);
         field_start_i = ($urandom_range(0, 60) == 0);
         field_id_i = 1'($urandom_range(0, 1));
         cycle("random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule